// File: doc/BRIEF.md
# Vectored Interrupt Controller with Relocatable Table

This block gathers level-sensitive interrupt requests from peripherals and picks one to hand to the processor. Each maskable vector (numbers 4 to 26) has an enable bit and a 3-bit priority level. A level of zero masks the vector. Among the requests that are both raised and enabled, the one with the highest level wins. When levels are equal, the lowest vector number wins. The winner is offered to the processor only when its level is strictly above the processor's current interrupt level.

Software places the vector table anywhere on a 256-byte boundary through a 24-bit base register, which is written as two halves. When the processor acknowledges, the block captures three values: the winning vector number, its level, and the address of its 4-byte table entry (base plus four times the vector number). It holds these values until the next acknowledge that finds a request pending.

Three vectors (12, 15 and 20) each take the OR of two peripheral request lines. Both lines on such a vector share that vector's single level and enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the table base reads 0x008000, every vector configuration reads 0, irq_pending is low, and vec_num, vec_level and vec_addr are 0.
- R2: Register address 0 holds base bits 15:8 in data bits 15:8, and data bits 7:0 always read 0. Address 1 holds base bits 23:16 in data bits 7:0, and data bits 15:8 read 0. Writes to the always-zero bits have no effect.
- R3: Register address 32+n is the configuration of vector n: bit 3 is the enable and bits 2:0 are the level. For n outside 4..26 the register reads 0, writes are ignored, and a raised request line never makes irq_pending go high.
- R4: A vector competes only when its request is high, its enable is 1 and its level is nonzero.
- R5: Among competing vectors, the one with the highest level is selected.
- R6: Among competing vectors of equal top level, the lowest vector number is selected.
- R7: irq_pending is high exactly when the selected level is strictly greater than cpu_level.
- R8: Vectors 12, 15 and 20 are requested by irq_req[n] OR irq_alt[0], irq_alt[1] and irq_alt[2] respectively. Both sources use that vector's one level and enable.
- R9: On a clock edge with ack and irq_pending both high, vec_num and vec_level take the selected vector and level. At all other edges, vec_num, vec_level and vec_addr hold their values.
- R10: The captured vec_addr equals the table base in effect at that acknowledge plus 4 times the captured vector number. A later base write does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_req | input | 32 | Request line per vector number |
| irq_alt | input | 3 | Second request lines for vectors 12, 15, 20 |
| cpu_level | input | 3 | Current processor interrupt level |
| ack | input | 1 | Processor acknowledge |
| irq_pending | output | 1 | A request above cpu_level is waiting |
| vec_num | output | 5 | Captured vector number |
| vec_level | output | 3 | Captured level |
| vec_addr | output | 24 | Captured table entry address |

## Verification
Corrupt enable or level storage shows up on the combinational irq_pending output in the same cycle the request is raised, or as a wrong vector number one cycle after the acknowledge. A damaged base register shows on the register read port at once. At the next acknowledge it also shows as a vec_addr that differs from base plus four times the vector. Capture faults show as outputs that change without an acknowledge, or that stay stale after one. The bench watches for both cases in the cycle right after each edge.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int LVL_W = 3,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE_RST = 24'h008000,
  parameter int VEC_LO = 4,
  parameter int VEC_HI = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [31:0]       irq_req,
  input  logic [2:0]        irq_alt,
  input  logic [LVL_W-1:0]  cpu_level,
  input  logic              ack,
  output logic              irq_pending,
  output logic [4:0]        vec_num,
  output logic [LVL_W-1:0]  vec_level,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int HI_W = ADDR_W - 16;
  localparam int SH0 = 12, SH1 = 15, SH2 = 20;

  logic [ADDR_W-9:0] base_hi;
  logic [31:0] en;
  logic [LVL_W-1:0] lvl [32];
  logic [31:0] req;
  logic [4:0] win_num;
  logic [LVL_W-1:0] win_lvl;

  wire [4:0] idx = reg_addr[4:0];
  wire cfg_sel = reg_addr[5] && int'(idx) >= VEC_LO && int'(idx) <= VEC_HI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= BASE_RST[ADDR_W-1:8];
      en <= '0;
      for (int i = 0; i < 32; i++) lvl[i] <= '0;
    end else if (reg_we) begin
      if (reg_addr == 6'd0) base_hi[7:0] <= reg_wdata[15:8];
      else if (reg_addr == 6'd1) base_hi[ADDR_W-9:8] <= reg_wdata[HI_W-1:0];
      else if (cfg_sel) begin
        en[idx] <= reg_wdata[LVL_W];
        lvl[idx] <= reg_wdata[LVL_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 6'd0) reg_rdata[15:8] = base_hi[7:0];
    else if (reg_addr == 6'd1) reg_rdata[HI_W-1:0] = base_hi[ADDR_W-9:8];
    else if (cfg_sel) begin
      reg_rdata[LVL_W] = en[idx];
      reg_rdata[LVL_W-1:0] = lvl[idx];
    end
  end

  always_comb begin
    req = irq_req;
    req[SH0] = irq_req[SH0] | irq_alt[0];
    req[SH1] = irq_req[SH1] | irq_alt[1];
    req[SH2] = irq_req[SH2] | irq_alt[2];
  end

  always_comb begin
    win_lvl = '0;
    win_num = '0;
    for (int i = VEC_HI; i >= VEC_LO; i--)
      if (req[i] && en[i] && lvl[i] != '0 && lvl[i] >= win_lvl) begin
        win_lvl = lvl[i];
        win_num = 5'(i);
      end
  end

  assign irq_pending = win_lvl > cpu_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_num <= '0;
      vec_level <= '0;
      vec_addr <= '0;
    end else if (ack && irq_pending) begin
      vec_num <= win_num;
      vec_level <= win_lvl;
      vec_addr <= {base_hi, 1'b0, win_num, 2'b00};
    end
  end
endmodule

module irq_vector_ctrl_chk #(
  parameter int LVL_W = 3,
  parameter int ADDR_W = 24,
  parameter int VEC_LO = 4,
  parameter int VEC_HI = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              irq_pending,
  input logic [LVL_W-1:0]  cpu_level,
  input logic [4:0]        vec_num,
  input logic [LVL_W-1:0]  vec_level,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [4:0]        win_num,
  input logic [LVL_W-1:0]  win_lvl,
  input logic [ADDR_W-9:0] base_hi,
  input logic [5:0]        reg_addr,
  input logic [15:0]       reg_rdata
);
  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 6'd0 |-> reg_rdata[7:0] == 8'h00); // R2
  AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (int'(win_num) >= VEC_LO && int'(win_num) <= VEC_HI)); // R3
  AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> win_lvl != '0); // R4
  AST_LEVEL_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    ack && irq_pending |=> vec_level > $past(cpu_level)); // R7
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ack && irq_pending |=> vec_num == $past(win_num) && vec_level == $past(win_lvl)); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && irq_pending) |=> $stable(vec_num) && $stable(vec_level) && $stable(vec_addr)); // R9
  AST_ADDR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ack && irq_pending |=> vec_addr == {$past(base_hi), 8'h00} + ADDR_W'(4 * $past(win_num))); // R10
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.LVL_W(LVL_W), .ADDR_W(ADDR_W), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .irq_pending(irq_pending), .cpu_level(cpu_level),
  .vec_num(vec_num), .vec_level(vec_level), .vec_addr(vec_addr), .win_num(win_num),
  .win_lvl(win_lvl), .base_hi(base_hi), .reg_addr(reg_addr), .reg_rdata(reg_rdata));

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic clk = 0, rst_n = 0, reg_we = 0, ack = 0;
  logic [5:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [31:0] irq_req = 0;
  logic [2:0] irq_alt = 0, cpu_level = 0, vec_level;
  logic irq_pending;
  logic [4:0] vec_num;
  logic [23:0] vec_addr;

  irq_vector_ctrl uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [23:0] m_base = 24'h008000;
  bit m_en [32];
  int m_lvl [32];
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(bit ok, string r, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 6'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 0;
    if (a == 0) m_base[15:8] = 8'(d >> 8);
    else if (a == 1) m_base[23:16] = 8'(d);
    else if (a >= 32 && a - 32 >= 4 && a - 32 <= 26) begin
      m_en[a-32] = d[3]; m_lvl[a-32] = d & 7;
    end
  endtask

  task automatic rd(int a, output int d);
    reg_addr = 6'(a); #1; d = int'(reg_rdata);
  endtask

  task automatic model(output bit p, output int n, output int l);
    logic [31:0] r;
    r = irq_req;
    r[12] |= irq_alt[0]; r[15] |= irq_alt[1]; r[20] |= irq_alt[2];
    n = 0; l = 0;
    for (int v = 4; v <= 26; v++)
      if (r[v] && m_en[v] && m_lvl[v] > l) begin l = m_lvl[v]; n = v; end
    p = l > int'(cpu_level);
  endtask

  task automatic settle_check(string r);
    bit p; int n, l;
    #1; model(p, n, l);
    chk(irq_pending == p, r, irq_pending, p);
    if (p) begin
      ack = 1; @(negedge clk); ack = 0; #1;
      chk(vec_num == 5'(n), r, vec_num, n);
      chk(vec_level == 3'(l), r, vec_level, l);
      chk(vec_addr == m_base + 24'(4 * n), "R10", vec_addr, m_base + 24'(4 * n));
    end
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5; return x;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    bit p; int n, l;
    for (int i = 0; i < 32; i++) begin m_en[i] = 0; m_lvl[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, d); chk(d == 16'h8000, "R1", d, 16'h8000);
    rd(1, d); chk(d == 0, "R1", d, 0);
    rd(32 + 9, d); chk(d == 0, "R1", d, 0);
    chk(irq_pending == 0 && vec_num == 0 && vec_level == 0 && vec_addr == 0, "R1",
        {vec_addr, vec_num}, 0);

    wr(0, 16'hABCD); rd(0, d); chk(d == 16'hAB00, "R2", d, 16'hAB00);
    wr(1, 16'h1234); rd(1, d); chk(d == 16'h0034, "R2", d, 16'h0034);

    for (int v = 0; v < 32; v++) wr(32 + v, 16'h000F);
    for (int v = 0; v < 32; v++) begin
      rd(32 + v, d);
      chk(d == ((v >= 4 && v <= 26) ? 15 : 0), "R3", d, (v >= 4 && v <= 26) ? 15 : 0);
    end
    @(negedge clk);
    irq_req = 32'hF800_000F; #1;
    chk(irq_pending == 0, "R3", irq_pending, 0);

    for (int v = 4; v <= 26; v++) begin
      @(negedge clk); irq_req = 32'h1 << v;
      settle_check("R9");
    end

    @(negedge clk); irq_req = 0;
    wr(32 + 10, 7); irq_req = 32'h1 << 10; #1;
    chk(irq_pending == 0, "R4", irq_pending, 0);
    wr(32 + 10, 8); #1;
    chk(irq_pending == 0, "R4", irq_pending, 0);

    for (int v = 4; v <= 26; v++) wr(32 + v, 16'h000D);
    @(negedge clk); irq_req = 32'h07FF_FFF0;
    settle_check("R6");
    @(negedge clk); irq_req = 32'h07FF_FE00;
    settle_check("R6");

    for (int v = 4; v <= 26; v++) wr(32 + v, 0);
    @(negedge clk); irq_req = 32'h1 << 9;
    for (int lv = 1; lv <= 7; lv++) begin
      wr(32 + 9, 8 | lv);
      for (int c = 0; c <= 7; c++) begin
        cpu_level = 3'(c); #1;
        chk(irq_pending == (lv > c), "R7", irq_pending, lv > c);
      end
    end
    cpu_level = 0;

    for (int k = 0; k < 3; k++) begin
      int sv;
      sv = (k == 0) ? 12 : (k == 1) ? 15 : 20;
      for (int v = 4; v <= 26; v++) wr(32 + v, 0);
      wr(32 + sv, 8 | 4);
      @(negedge clk); irq_req = 0; irq_alt = 3'(1 << k);
      settle_check("R8");
      chk(vec_num == 5'(sv), "R8", vec_num, sv);
      wr(32 + sv, 8 | 2);
      @(negedge clk); cpu_level = 3; #1;
      chk(irq_pending == 0, "R8", irq_pending, 0);
      irq_alt = 0; irq_req = 32'h1 << sv; #1;
      chk(irq_pending == 0, "R8", irq_pending, 0);
      cpu_level = 1; #1;
      chk(irq_pending == 1, "R8", irq_pending, 1);
      cpu_level = 0; irq_req = 0;
    end

    wr(32 + 5, 8 | 6); wr(32 + 22, 8 | 3);
    @(negedge clk); irq_req = 32'h1 << 5;
    settle_check("R9");
    @(negedge clk); irq_req = 32'h1 << 22;
    repeat (3) @(negedge clk);
    chk(vec_num == 5, "R9", vec_num, 5);
    irq_req = 0; ack = 1; @(negedge clk); ack = 0; #1;
    chk(vec_num == 5 && vec_level == 6, "R9", vec_num, 5);
    chk(vec_addr == m_base + 24'd20, "R10", vec_addr, m_base + 24'd20);
    wr(0, 16'h5500); wr(1, 16'h0077);
    chk(vec_addr == 24'h34AB14, "R10", vec_addr, 24'h34AB14);
    irq_req = 32'h1 << 22;
    settle_check("R10");
    chk(vec_addr == 24'h775558, "R10", vec_addr, 24'h775558);

    for (int t = 0; t < 250; t++) begin
      for (int v = 4; v <= 26; v++) begin
        rng = nxt(rng);
        wr(32 + v, int'(rng[3:0]));
      end
      rng = nxt(rng);
      @(negedge clk);
      irq_req = rng; irq_alt = rng[31:29];
      rng = nxt(rng);
      cpu_level = rng[2:0] & {1'b0, rng[3], 1'b1};
      settle_check("R5");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule